// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

The walker drives the descriptor side of an Ethernet transmit path. Software builds a ring of two-word descriptors in system memory. Word 0 holds a buffer address. Word 1 holds the buffer length, a frame-end flag, a wrap flag and an ownership flag. Software then programs the ring base and raises the transmit enable. From then on the walker reads descriptors in ring order and hands each buffer to a downstream data mover as an address/length request. When the last buffer of a frame has been accepted, it returns the frame to software by setting the ownership flag in the first descriptor of that frame.

The walk stops in three cases: on a descriptor that software still holds, on a frame that asks for more buffers than the per-frame cap, or when transmit is disabled at a frame boundary. Every stop parks the walker. A new walk always starts again from the ring base, after transmit enable has been dropped and raised again.

The state machine has eight states:
- `WLK_IDLE` waits for enable and is the only state that accepts a new base.
- `WLK_RD_ADDR` reads word 0.
- `WLK_RD_CTRL` reads word 1.
- `WLK_DECIDE` checks ownership and the cap.
- `WLK_OFFER` presents the buffer.
- `WLK_RETIRE` writes back the first descriptor of the frame.
- `WLK_FINISH` flags the completed frame.
- `WLK_HALT` is parked after a stop.

The transitions are:
- IDLE→RD_ADDR on enable.
- RD_ADDR→RD_CTRL and RD_CTRL→DECIDE on memory acknowledge.
- DECIDE→HALT when the descriptor is held by software or the cap is reached, otherwise DECIDE→OFFER.
- OFFER→RD_ADDR on accept of a non-final buffer, OFFER→RETIRE on accept of a final one.
- RETIRE→FINISH on acknowledge.
- FINISH→RD_ADDR while enabled, otherwise FINISH→IDLE.
- HALT→IDLE once enable is low.

Top module: `tx_desc_ring_walker`

## Requirements
- R1: Descriptor i sits at base + 8·i. The walker reads word 0 at offset +0 and then word 1 at +4. The three low bits of a written base are ignored. A memory request holds its address and direction until acknowledged.
- R2: If word 1 bit 31 is 1 (held by software), the walker issues no buffer request and gives exactly one used-descriptor pulse. It then makes no memory access and no buffer request until restarted.
- R3: If word 1 bit 30 (wrap) is set, the descriptor after it is the one at the ring base.
- R4: Without a wrap flag, the descriptor after index RING_MAX−1 (1023 by default) is the one at the ring base.
- R5: A buffer request carries buffer address = word 0, length = word 1 bits 10:0 and final = word 1 bit 15. The request stays valid and unchanged until accepted.
- R6: After the final buffer of a frame is accepted, the walker makes one memory write. The write goes to word 1 of the frame's first descriptor and carries its original value with bit 31 set. A frame-done pulse follows.
- R7: A frame may use at most MAX_BUFS (128) buffers. A 129th descriptor of the same frame gives an error pulse, no buffer request and no write-back, and the walk stops. A frame of exactly 128 buffers completes normally.
- R8: No memory access happens while transmit enable is low and the walker is idle. The base is loaded only then; a base write while enabled is ignored.
- R9: After a stop, dropping and raising transmit enable restarts the walk at the ring base.
- R10: After reset, no memory request, no buffer request and no status pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tx_en | input | 1 | Transmit enable level |
| qptr_wr | input | 1 | Ring base write strobe |
| qptr_data | input | 32 | Ring base byte address |
| mem_req | output | 1 | Descriptor memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Descriptor word byte address |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Request done; read data valid with it |
| mem_rdata | input | 32 | Read data |
| buf_valid | output | 1 | Buffer request valid |
| buf_addr | output | 32 | Buffer start address |
| buf_len | output | 11 | Buffer length in bytes |
| buf_last | output | 1 | Final buffer of the frame |
| buf_ready | input | 1 | Data mover accepts the request |
| stat_used_read | output | 1 | Pulse: stopped on a software-held descriptor |
| stat_frame_err | output | 1 | Pulse: frame exceeded the buffer cap |
| stat_frame_done | output | 1 | Pulse: frame returned to software |

## Verification
The assertions cover the per-cycle rules on every cycle:
- memory and buffer requests hold steady while stalled;
- every write sets the ownership bit and targets a word 1;
- status pulses never coincide;
- the buffer counter is never stepped past its cap;
- the walker goes quiet right after a used-descriptor stop.

Only the bench scenarios can show the rest, because each needs a whole ring of memory to play out:
- the order in which descriptors are visited, including the wrap flag and the forced wrap after the last index;
- the content of the write-backs;
- the abort on the 129th buffer;
- that base writes during a walk are ignored;
- the restart from the base.

// File: rtl/txd_pkg.sv
package txd_pkg;

    // Descriptor word 1 field positions (decoded by software as well)
    localparam int DESC_OWN_BIT  = 31;
    localparam int DESC_WRAP_BIT = 30;
    localparam int DESC_LAST_BIT = 15;
    localparam int DESC_LEN_W    = 11;
    localparam int DESC_W        = 32;

    typedef enum logic [2:0] {
        WLK_IDLE,
        WLK_RD_ADDR,
        WLK_RD_CTRL,
        WLK_DECIDE,
        WLK_OFFER,
        WLK_RETIRE,
        WLK_FINISH,
        WLK_HALT
    } walk_state_e;

endpackage

// File: rtl/txd_ring_ptr.sv
module txd_ring_ptr #(
    parameter  int RING_MAX = 1024,
    localparam int IDX_W    = (RING_MAX > 1) ? $clog2(RING_MAX) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic             wrap,
    input  logic             mark,
    output logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] first_idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RING_MAX - 1);

    logic at_end;
    assign at_end = (idx == LAST_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx       <= '0;
            first_idx <= '0;
        end else begin
            if (clr) begin
                idx <= '0;
            end else if (adv) begin
                idx <= (wrap || at_end) ? '0 : idx + IDX_W'(1);
            end
            if (mark) begin
                first_idx <= idx;
            end
        end
    end

endmodule

// File: rtl/txd_buf_counter.sv
module txd_buf_counter #(
    parameter  int MAX_BUFS = 128,
    localparam int CNT_W    = $clog2(MAX_BUFS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic is_first,
    output logic cap_hit
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign is_first = (cnt == '0);
    assign cap_hit  = (cnt == CNT_W'(MAX_BUFS));

    // R7: the state machine never counts a buffer beyond the cap
    assert_cap_respected_R7: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> (cnt < CNT_W'(MAX_BUFS)));

endmodule

// File: rtl/txd_walk_fsm.sv
module txd_walk_fsm
    import txd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic mem_ack,
    input  logic buf_ready,
    input  logic desc_own,
    input  logic desc_last,
    input  logic cap_hit,
    output logic mem_req,
    output logic mem_we,
    output logic sel_ctrl,
    output logic sel_wb,
    output logic cap_w0,
    output logic cap_w1,
    output logic offer,
    output logic ptr_clr,
    output logic ptr_adv,
    output logic cnt_inc,
    output logic cnt_clr,
    output logic base_ld_ok,
    output logic used_pulse,
    output logic err_pulse,
    output logic done_pulse
);

    walk_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= WLK_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WLK_IDLE:    if (tx_en) st_d = WLK_RD_ADDR;
            WLK_RD_ADDR: if (mem_ack) st_d = WLK_RD_CTRL;
            WLK_RD_CTRL: if (mem_ack) st_d = WLK_DECIDE;
            WLK_DECIDE:  st_d = (desc_own || cap_hit) ? WLK_HALT : WLK_OFFER;
            WLK_OFFER:   if (buf_ready) st_d = desc_last ? WLK_RETIRE : WLK_RD_ADDR;
            WLK_RETIRE:  if (mem_ack) st_d = WLK_FINISH;
            WLK_FINISH:  st_d = tx_en ? WLK_RD_ADDR : WLK_IDLE;
            WLK_HALT:    if (!tx_en) st_d = WLK_IDLE;
            default:     st_d = WLK_IDLE;
        endcase
    end

    always_comb begin
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        sel_ctrl   = 1'b0;
        sel_wb     = 1'b0;
        cap_w0     = 1'b0;
        cap_w1     = 1'b0;
        offer      = 1'b0;
        ptr_clr    = 1'b0;
        ptr_adv    = 1'b0;
        cnt_inc    = 1'b0;
        cnt_clr    = 1'b0;
        base_ld_ok = 1'b0;
        used_pulse = 1'b0;
        err_pulse  = 1'b0;
        done_pulse = 1'b0;
        unique case (st_q)
            WLK_IDLE: begin
                base_ld_ok = 1'b1;
                cnt_clr    = 1'b1;
                ptr_clr    = !tx_en;
            end
            WLK_RD_ADDR: begin
                mem_req = 1'b1;
                cap_w0  = mem_ack;
            end
            WLK_RD_CTRL: begin
                mem_req  = 1'b1;
                sel_ctrl = 1'b1;
                cap_w1   = mem_ack;
            end
            WLK_DECIDE: begin
                used_pulse = desc_own;
                err_pulse  = !desc_own && cap_hit;
                cnt_inc    = !desc_own && !cap_hit;
            end
            WLK_OFFER: begin
                offer   = 1'b1;
                ptr_adv = buf_ready;
            end
            WLK_RETIRE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                sel_wb  = 1'b1;
            end
            WLK_FINISH: begin
                done_pulse = 1'b1;
                cnt_clr    = 1'b1;
            end
            WLK_HALT: begin
                cnt_clr = 1'b1;
                ptr_clr = !tx_en;
            end
            default: begin
                cnt_clr = 1'b1;
            end
        endcase
    end

    // R8: an idle walker with transmit disabled issues no memory access next cycle
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (base_ld_ok && !tx_en) |=> !mem_req);

endmodule

// File: rtl/tx_desc_ring_walker.sv
module tx_desc_ring_walker
    import txd_pkg::*;
#(
    parameter int AW       = 32,
    parameter int RING_MAX = 1024,
    parameter int MAX_BUFS = 128
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tx_en,
    input  logic                  qptr_wr,
    input  logic [AW-1:0]         qptr_data,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [AW-1:0]         mem_addr,
    output logic [DESC_W-1:0]     mem_wdata,
    input  logic                  mem_ack,
    input  logic [DESC_W-1:0]     mem_rdata,
    output logic                  buf_valid,
    output logic [DESC_W-1:0]     buf_addr,
    output logic [DESC_LEN_W-1:0] buf_len,
    output logic                  buf_last,
    input  logic                  buf_ready,
    output logic                  stat_used_read,
    output logic                  stat_frame_err,
    output logic                  stat_frame_done
);

    localparam int IDX_W = (RING_MAX > 1) ? $clog2(RING_MAX) : 1;
    localparam logic [AW-1:0] BASE_MASK = ~AW'(7);
    localparam logic [DESC_W-1:0] OWN_SET = DESC_W'(1) << DESC_OWN_BIT;

    logic [DESC_W-1:0] w0_q, w1_q, first_ctrl_q;
    logic [AW-1:0]     base_q;
    logic [IDX_W-1:0]  idx, first_idx;

    logic sel_ctrl, sel_wb, cap_w0, cap_w1, offer;
    logic ptr_clr, ptr_adv, cnt_inc, cnt_clr, base_ld_ok;
    logic is_first, cap_hit, frame_mark;

    assign frame_mark = cnt_inc && is_first;

    txd_walk_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .mem_ack    (mem_ack),
        .buf_ready  (buf_ready),
        .desc_own   (w1_q[DESC_OWN_BIT]),
        .desc_last  (w1_q[DESC_LAST_BIT]),
        .cap_hit    (cap_hit),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .sel_ctrl   (sel_ctrl),
        .sel_wb     (sel_wb),
        .cap_w0     (cap_w0),
        .cap_w1     (cap_w1),
        .offer      (offer),
        .ptr_clr    (ptr_clr),
        .ptr_adv    (ptr_adv),
        .cnt_inc    (cnt_inc),
        .cnt_clr    (cnt_clr),
        .base_ld_ok (base_ld_ok),
        .used_pulse (stat_used_read),
        .err_pulse  (stat_frame_err),
        .done_pulse (stat_frame_done)
    );

    txd_ring_ptr #(.RING_MAX(RING_MAX)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (ptr_clr),
        .adv       (ptr_adv),
        .wrap      (w1_q[DESC_WRAP_BIT]),
        .mark      (frame_mark),
        .idx       (idx),
        .first_idx (first_idx)
    );

    txd_buf_counter #(.MAX_BUFS(MAX_BUFS)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .inc      (cnt_inc),
        .is_first (is_first),
        .cap_hit  (cap_hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w0_q         <= '0;
            w1_q         <= '0;
            first_ctrl_q <= '0;
            base_q       <= '0;
        end else begin
            if (cap_w0)     w0_q         <= mem_rdata;
            if (cap_w1)     w1_q         <= mem_rdata;
            if (frame_mark) first_ctrl_q <= w1_q;
            if (qptr_wr && base_ld_ok && !tx_en) begin
                base_q <= qptr_data & BASE_MASK;
            end
        end
    end

    always_comb begin
        if (sel_wb) begin
            mem_addr = base_q + AW'({first_idx, 3'b100});
        end else begin
            mem_addr = base_q + AW'({idx, sel_ctrl, 2'b00});
        end
    end

    assign mem_wdata = first_ctrl_q | OWN_SET;
    assign buf_valid = offer;
    assign buf_addr  = w0_q;
    assign buf_len   = w1_q[DESC_LEN_W-1:0];
    assign buf_last  = w1_q[DESC_LAST_BIT];

    // R1: a stalled memory request keeps its address and direction
    assert_req_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R5: a stalled buffer request keeps its fields
    assert_offer_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_valid && !buf_ready) |=> (buf_valid && $stable(buf_addr)
                                       && $stable(buf_len) && $stable(buf_last)));

    // R6: every write hands a word 1 back to software
    assert_wb_owned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[DESC_OWN_BIT] && (mem_addr[2:0] == 3'b100)));

    // R2: after a used-descriptor stop the walker goes quiet
    assert_stop_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stat_used_read |=> (!mem_req && !buf_valid));

    // R7: status pulses never coincide
    assert_pulse_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stat_used_read, stat_frame_err, stat_frame_done}));

endmodule

// File: tb/tx_desc_ring_walker_test.sv
module tx_desc_ring_walker_test;

    localparam int CLK_PERIOD = 10;
    localparam int RING       = 1024;
    localparam int CAP        = 128;
    localparam logic [31:0] BASE_A = 32'h0010_0000;
    localparam logic [31:0] BASE_B = 32'h0023_2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0;
    logic        qptr_wr = 1'b0;
    logic [31:0] qptr_data = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        buf_valid;
    logic [31:0] buf_addr;
    logic [10:0] buf_len;
    logic        buf_last;
    logic        buf_ready = 1'b0;
    logic        stat_used_read, stat_frame_err, stat_frame_done;

    tx_desc_ring_walker uut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en),
        .qptr_wr(qptr_wr), .qptr_data(qptr_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .buf_valid(buf_valid), .buf_addr(buf_addr), .buf_len(buf_len),
        .buf_last(buf_last), .buf_ready(buf_ready),
        .stat_used_read(stat_used_read), .stat_frame_err(stat_frame_err),
        .stat_frame_done(stat_frame_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [31:0] mem    [4096];
    logic [31:0] shadow [4096];
    int checks = 0;
    int errors = 0;
    logic [31:0] cur_base = '0;

    logic [31:0] exp_addr[$], obs_addr[$];
    logic [10:0] exp_len[$],  obs_len[$];
    logic        exp_last[$], obs_last[$];
    logic [31:0] exp_wba[$], exp_wbd[$], obs_wba[$], obs_wbd[$];
    int exp_used, exp_err, exp_done;
    int obs_used = 0, obs_err = 0, obs_done = 0, obs_oob = 0, act_cnt = 0;
    logic [31:0] exp_last_rd, obs_last_rd = '0;

    function automatic int widx(input logic [31:0] a);
        return int'(a[13:2]);
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Memory responder and data mover: drive at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            mem_ack   = 1'b0;
            buf_ready = 1'b0;
            if (rst_n) begin
                if (stat_used_read)  obs_used++;
                if (stat_frame_err)  obs_err++;
                if (stat_frame_done) obs_done++;
                if (mem_req || buf_valid) act_cnt++;
                if (mem_req && ($urandom_range(2, 0) != 0)) begin
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        mem[widx(mem_addr)] = mem_wdata;
                        obs_wba.push_back(mem_addr);
                        obs_wbd.push_back(mem_wdata);
                    end else begin
                        mem_rdata   = mem[widx(mem_addr)];
                        obs_last_rd = mem_addr;
                        if ((mem_addr - cur_base) >= 32'h2000) obs_oob++;
                    end
                end
                if (buf_valid && ($urandom_range(3, 0) != 0)) begin
                    buf_ready = 1'b1;
                    obs_addr.push_back(buf_addr);
                    obs_len.push_back(buf_len);
                    obs_last.push_back(buf_last);
                end
            end
        end
    end

    task automatic put_desc(input logic [31:0] base, input int i,
                            input logic [31:0] w0, input logic [31:0] w1);
        mem[widx(base + 32'(i) * 8)]     = w0;
        mem[widx(base + 32'(i) * 8 + 4)] = w1;
    endtask

    task automatic fill_owned(input logic [31:0] base);
        for (int i = 0; i < RING; i++) put_desc(base, i, 32'h0, 32'h8000_0000);
    endtask

    // random word 1: reserved bits random, length in 10:0, final flag in 15
    function automatic logic [31:0] mk_ctrl(input int len, input bit fin, input bit wrp);
        logic [31:0] w;
        w = $urandom() & 32'h3FFF_7800;
        w[10:0] = 11'(len);
        w[15]   = fin;
        w[30]   = wrp;
        return w;
    endfunction

    task automatic build_random(input logic [31:0] base, input int n, input bit wrap_end);
        int i, k;
        fill_owned(base);
        i = 0;
        while (i < n) begin
            k = int'($urandom_range(5, 1));
            if (k > n - i) k = n - i;
            for (int j = 0; j < k; j++) begin
                int len;
                len = int'($urandom_range(2047, 1));
                if (i + j == 0) len = 1;
                if (i + j == 1) len = 2047;
                put_desc(base, i + j, $urandom(),
                         mk_ctrl(len, j == k - 1, wrap_end && (i + j == n - 1)));
            end
            i += k;
        end
    endtask

    // Expected walk, derived from the requirements
    task automatic run_model(input logic [31:0] base);
        int idx, cnt, first;
        shadow = mem;
        exp_addr.delete(); exp_len.delete(); exp_last.delete();
        exp_wba.delete(); exp_wbd.delete();
        exp_used = 0; exp_err = 0; exp_done = 0;
        idx = 0; cnt = 0; first = 0;
        for (int step = 0; step < 3000; step++) begin
            logic [31:0] w0, w1, wa;
            w0 = shadow[widx(base + 32'(idx) * 8)];
            w1 = shadow[widx(base + 32'(idx) * 8 + 4)];
            exp_last_rd = base + 32'(idx) * 8 + 4;
            if (w1[31]) begin exp_used = 1; break; end
            if (cnt == CAP) begin exp_err = 1; break; end
            if (cnt == 0) first = idx;
            cnt++;
            exp_addr.push_back(w0);
            exp_len.push_back(w1[10:0]);
            exp_last.push_back(w1[15]);
            if (w1[15]) begin
                wa = base + 32'(first) * 8 + 4;
                shadow[widx(wa)] = shadow[widx(wa)] | 32'h8000_0000;
                exp_wba.push_back(wa);
                exp_wbd.push_back(shadow[widx(wa)]);
                exp_done++;
                cnt = 0;
            end
            idx = (w1[30] || idx == RING - 1) ? 0 : idx + 1;
        end
    endtask

    task automatic load_base(input logic [31:0] base);
        @(negedge clk);
        qptr_wr   = 1'b1;
        qptr_data = base | 32'h5;   // low bits must be ignored (R1)
        @(negedge clk);
        qptr_wr   = 1'b0;
        cur_base  = base;
    endtask

    task automatic walk(input logic [31:0] base, input bit disturb,
                        input string rd_tag, input string stop_tag);
        int n, mism, snap;
        tx_en = 1'b0;
        repeat (4) @(negedge clk);
        load_base(base);
        run_model(base);
        obs_addr.delete(); obs_len.delete(); obs_last.delete();
        obs_wba.delete(); obs_wbd.delete();
        obs_used = 0; obs_err = 0; obs_done = 0; obs_oob = 0;
        @(negedge clk);
        tx_en = 1'b1;
        if (disturb) begin
            repeat (25) @(negedge clk);
            qptr_wr = 1'b1; qptr_data = 32'h00BA_D000;
            @(negedge clk);
            qptr_wr = 1'b0;
        end
        n = 0;
        while ((obs_used + obs_err) == 0 && n < 60000) begin
            @(negedge clk);
            n++;
        end
        repeat (5) @(negedge clk);
        snap = act_cnt;
        repeat (20) @(negedge clk);
        check(act_cnt == snap, stop_tag, "activity after stop", 32'(act_cnt - snap), 0);
        check(obs_addr.size() == exp_addr.size(), "R5", "buffer count",
              32'(obs_addr.size()), 32'(exp_addr.size()));
        mism = 0;
        for (int i = 0; i < exp_addr.size() && i < obs_addr.size(); i++)
            if (obs_addr[i] != exp_addr[i] || obs_len[i] != exp_len[i] ||
                obs_last[i] != exp_last[i]) mism++;
        check(mism == 0, "R5", "buffer field mismatches", 32'(mism), 0);
        check(obs_wba.size() == exp_wba.size(), "R6", "write-back count",
              32'(obs_wba.size()), 32'(exp_wba.size()));
        mism = 0;
        for (int i = 0; i < exp_wba.size() && i < obs_wba.size(); i++)
            if (obs_wba[i] != exp_wba[i] || obs_wbd[i] != exp_wbd[i]) mism++;
        check(mism == 0, "R6", "write-back mismatches", 32'(mism), 0);
        check(obs_done == exp_done, "R6", "frame-done pulses", 32'(obs_done), 32'(exp_done));
        check(obs_used == exp_used, "R2", "used pulses", 32'(obs_used), 32'(exp_used));
        check(obs_err == exp_err, "R7", "error pulses", 32'(obs_err), 32'(exp_err));
        check(obs_last_rd == exp_last_rd, rd_tag, "last descriptor read", obs_last_rd, exp_last_rd);
        check(obs_oob == 0, "R8", "reads outside ring", 32'(obs_oob), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int snap;
        void'($urandom(32'd1207));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: quiet after reset
        check(!mem_req && !buf_valid, "R10", "requests after reset",
              {30'b0, mem_req, buf_valid}, 0);
        check(!stat_used_read && !stat_frame_err && !stat_frame_done, "R10",
              "pulses after reset",
              {29'b0, stat_used_read, stat_frame_err, stat_frame_done}, 0);

        // R8: base loaded, transmit disabled: nothing moves
        build_random(BASE_A, 12, 1'b1);
        load_base(BASE_A);
        snap = act_cnt;
        repeat (30) @(negedge clk);
        check(act_cnt == snap, "R8", "activity while disabled", 32'(act_cnt - snap), 0);

        // R3: random frames, wrap flag on the last entry, stop on returned entry 0
        build_random(BASE_A, 40, 1'b1);
        walk(BASE_A, 1'b0, "R3", "R2");

        // R2: software-held descriptor mid ring
        build_random(BASE_B, 10, 1'b0);
        walk(BASE_B, 1'b0, "R1", "R2");
        // R9: restart reads from the base, entry 0 now returned
        walk(BASE_B, 1'b0, "R9", "R2");

        // R8: base write during a walk is ignored
        build_random(BASE_A, 30, 1'b1);
        walk(BASE_A, 1'b1, "R3", "R2");

        // R4: full ring without wrap flag, frames of eight buffers
        fill_owned(BASE_B);
        for (int i = 0; i < RING; i++)
            put_desc(BASE_B, i, $urandom(),
                     mk_ctrl(int'($urandom_range(2047, 1)), (i % 8) == 7, 1'b0));
        walk(BASE_B, 1'b0, "R4", "R2");

        // R7: a 128-buffer frame completes, the next with 129 aborts
        fill_owned(BASE_A);
        for (int i = 0; i < 2 * CAP + 1; i++)
            put_desc(BASE_A, i, $urandom(),
                     mk_ctrl(int'($urandom_range(2047, 1)), i == CAP - 1, 1'b0));
        walk(BASE_A, 1'b0, "R7", "R7");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule